// File: doc/BRIEF.md
# Calibration Retention Table Controller

This block keeps radio calibration results so that they can be replayed to the analog front end without recalibrating. Each receive chain owns a six-entry table of 28-bit words. Entries 0, 1 and 2 hold the DC-offset DAC results for the loop, low and high settings. Entry 3 holds the filter cutoff result, entry 4 the receive gain setting and entry 5 the peak-detector offset.

A host reaches the block through a flat register space with a write strobe and a combinational read port. Each chain has a command register and a data register. To access the table, the host first places a word in the data register if it is writing. It then writes the command register with the entry index, the direction bit and the start bit. The start bit reads back as 1 while the access is in flight and drops by itself when the access is done. A shared control register holds an enable bit, a per-entry restore mask and a force-restore bit. When force-restore is set while the enable bit is on, the block walks the six entries in index order, one per clock. For each entry selected by the mask it presents the stored word on every active chain's restore bus, together with a valid strobe and the index. The force-restore bit clears itself when the walk is over.

Top module: `calret_top`

## Requirements
- R1: After reset every register reads 0 and every table entry reads back as 0. The register map is: address 0 is the control register; address 1+2c is chain c's command register; address 2+2c is chain c's data register. Any other address reads 0.
- R2: The command register has the entry index in bits [2:0], the write bit in bit 3 and the start bit in bit 4. A start with the write bit at 1 stores data-register bits [27:0] into the addressed entry. A start with the write bit at 0 copies the addressed entry into the data register. Chains are independent of one another.
- R3: For a chain in the chain-enable mask, the start bit reads 1 for exactly 2 cycles after the write that sets it, then reads 0. The read result is visible in the data register once the start bit reads 0.
- R4: While a chain's start bit is 1, writes to that chain's command register and data register are ignored.
- R5: For a chain outside the chain-enable mask, the start bit reads 1 for exactly 1 cycle and the table is not changed.
- R6: An entry index of 6 or 7 is out of range. A write to it changes no entry, and a read of it returns 0.
- R7: The control register has enable in bit 0, the restore mask in bits [6:1] (mask bit i selects entry i) and force-restore in bit 7. Setting force-restore starts a walk over indices 0 to 5, one index per cycle, beginning in the cycle after the write. The force bit reads 1 for exactly those 6 cycles.
- R8: In walk cycle k, the restore index output equals k. A chain's valid strobe is high only when mask bit k is set and the chain is in the chain-enable mask. When the strobe is high, that chain's restore data equals its entry k.
- R9: A write that sets force-restore with the enable bit at 0 starts no walk: the force bit reads 0 and no valid strobe rises. Writing 0 to the control register clears all of its fields.
- R10: Control-register writes made during a walk are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chainEn | input | NCH | Chain-enable mask, one bit per chain |
| regWe | input | 1 | Register write strobe |
| regAddr | input | AW | Register address for both writes and reads |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Combinational read data at regAddr |
| rstValid | output | NCH | Restore valid strobe per chain |
| rstIdx | output | 3 | Entry index of the current restore cycle |
| rstData | output | NCH*DW | Restore data, chain c in bits [c*DW +: DW] |

## Verification
The handshake is exercised with a seeded random mix of writes and reads across all chains and all six entries. A scoreboard catches a wrong entry, a wrong chain or a lost write, and a cycle count of every access catches a change in latency. Directed cases cover the ground that random traffic misses. These are: overlapping command and data writes during a busy access, a masked-off chain, out-of-range indices, and the single-entry restore mask alongside random masks with one chain disabled. Together they separate a walk that skips masked entries from one that leaks them. They also separate a valid strobe that ignores the chain mask, and a force bit that starts without the enable bit or accepts control writes mid-walk.

// File: rtl/calret_pkg.sv
package calret_pkg;
  localparam int CR_IDX_W = 3;
  localparam int CR_REG_W = 32;

  // command register field positions
  localparam int CMD_WR_BIT  = 3;
  localparam int CMD_ACC_BIT = 4;

  // control register field positions
  localparam int CTL_EN_BIT    = 0;
  localparam int CTL_MASK_LSB  = 1;
  localparam int CTL_FORCE_BIT = 7;

  typedef struct packed {
    logic                hostDataWr;
    logic                tblWrite;
    logic                tblRead;
    logic [CR_IDX_W-1:0] entry;
  } chainStrobe_t;
endpackage

// File: rtl/calret_ctrl.sv
module calret_ctrl
  import calret_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int DW    = 28,
  parameter int DEPTH = 6,
  parameter int AW    = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NCH-1:0]                chainEn,
  input  logic                          regWe,
  input  logic [AW-1:0]                 regAddr,
  input  logic [CR_REG_W-1:0]           regWdata,
  input  logic [NCH-1:0][DW-1:0]        dataRegs,
  output logic [CR_REG_W-1:0]           regRdata,
  output chainStrobe_t                  strobes [NCH],
  output logic [NCH-1:0]                rstValid,
  output logic [CR_IDX_W-1:0]           rstIdx
);
  localparam logic [CR_IDX_W-1:0] LAST_IDX = CR_IDX_W'(DEPTH - 1);

  logic             enBit;
  logic             forceBit;
  logic [DEPTH-1:0] maskR;
  logic [CR_IDX_W-1:0] walkIdx;
  logic             ctrlHit;

  assign ctrlHit = regWe && (regAddr == '0);

  // restore walker and control register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBit    <= 1'b0;
      forceBit <= 1'b0;
      maskR    <= '0;
      walkIdx  <= '0;
    end else if (forceBit) begin
      if (walkIdx == LAST_IDX) begin
        forceBit <= 1'b0;
        walkIdx  <= '0;
      end else begin
        walkIdx <= walkIdx + 1'b1;
      end
    end else if (ctrlHit) begin
      enBit    <= regWdata[CTL_EN_BIT];
      maskR    <= regWdata[CTL_MASK_LSB +: DEPTH];
      forceBit <= regWdata[CTL_FORCE_BIT] & regWdata[CTL_EN_BIT];
      walkIdx  <= '0;
    end
  end

  assign rstIdx = walkIdx;

  logic [NCH-1:0]      accBusy;
  logic [NCH-1:0]      accWr;
  logic [CR_IDX_W-1:0] accEntry [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_chain
    localparam logic [AW-1:0] CMD_A  = AW'(1 + 2 * c);
    localparam logic [AW-1:0] DATA_A = AW'(2 + 2 * c);

    logic                busyR;
    logic                phaseR;
    logic                wrR;
    logic [CR_IDX_W-1:0] entryR;
    logic                cmdHit;
    logic                dataHit;
    logic                finish;

    assign cmdHit  = regWe && (regAddr == CMD_A);
    assign dataHit = regWe && (regAddr == DATA_A);
    assign finish  = busyR && chainEn[c] && phaseR;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        busyR  <= 1'b0;
        phaseR <= 1'b0;
        wrR    <= 1'b0;
        entryR <= '0;
      end else if (busyR) begin
        if (!chainEn[c] || phaseR) begin
          busyR  <= 1'b0;
          phaseR <= 1'b0;
        end else begin
          phaseR <= 1'b1;
        end
      end else if (cmdHit) begin
        entryR <= regWdata[CR_IDX_W-1:0];
        wrR    <= regWdata[CMD_WR_BIT];
        busyR  <= regWdata[CMD_ACC_BIT];
        phaseR <= 1'b0;
      end
    end

    assign strobes[c].hostDataWr = dataHit && !busyR;
    assign strobes[c].tblWrite   = finish && wrR;
    assign strobes[c].tblRead    = finish && !wrR;
    assign strobes[c].entry      = entryR;

    assign accBusy[c]  = busyR;
    assign accWr[c]    = wrR;
    assign accEntry[c] = entryR;

    assign rstValid[c] = forceBit && maskR[walkIdx] && chainEn[c];

    // R3
    access_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
      busyR && $past(busyR) |=> !busyR);

    // R5
    masked_chain_chk: assert property (@(posedge clk) disable iff (!rstN)
      busyR && !chainEn[c] |=> !busyR);

    // R4
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      busyR && $past(busyR) |-> $stable(entryR) && $stable(wrR));
  end

  // read-back multiplexer
  always_comb begin
    regRdata = '0;
    if (regAddr == '0) begin
      regRdata[CTL_EN_BIT]              = enBit;
      regRdata[CTL_MASK_LSB +: DEPTH]   = maskR;
      regRdata[CTL_FORCE_BIT]           = forceBit;
    end
    for (int c = 0; c < NCH; c++) begin
      if (regAddr == AW'(1 + 2 * c)) begin
        regRdata[CR_IDX_W-1:0] = accEntry[c];
        regRdata[CMD_WR_BIT]   = accWr[c];
        regRdata[CMD_ACC_BIT]  = accBusy[c];
      end else if (regAddr == AW'(2 + 2 * c)) begin
        regRdata[DW-1:0] = dataRegs[c];
      end
    end
  end

  // R7
  walk_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(forceBit) |-> $past(walkIdx) == LAST_IDX);

  // R10
  ctrl_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    forceBit && $past(forceBit) |-> $stable(maskR) && $stable(enBit));
endmodule

// File: rtl/calret_dp.sv
module calret_dp
  import calret_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int DW    = 28,
  parameter int DEPTH = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  chainStrobe_t           strobes [NCH],
  input  logic [CR_REG_W-1:0]    regWdata,
  input  logic [CR_IDX_W-1:0]    rstIdx,
  output logic [NCH-1:0][DW-1:0] dataRegs,
  output logic [NCH*DW-1:0]      rstData
);
  for (genvar c = 0; c < NCH; c++) begin : g_bank
    logic [DW-1:0] tbl [DEPTH];
    logic [DW-1:0] dataR;
    logic          inRange;

    assign inRange = (strobes[c].entry < CR_IDX_W'(DEPTH));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
      end else if (strobes[c].tblWrite && inRange) begin
        tbl[strobes[c].entry] <= dataR;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dataR <= '0;
      end else if (strobes[c].tblRead) begin
        dataR <= inRange ? tbl[strobes[c].entry] : '0;
      end else if (strobes[c].hostDataWr) begin
        dataR <= regWdata[DW-1:0];
      end
    end

    assign dataRegs[c]           = dataR;
    assign rstData[c*DW +: DW]   = (rstIdx < CR_IDX_W'(DEPTH)) ? tbl[rstIdx] : '0;

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({strobes[c].tblWrite, strobes[c].tblRead, strobes[c].hostDataWr}));

    // R6
    oob_read_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobes[c].tblRead && !inRange |=> dataR == '0);
  end
endmodule

// File: rtl/calret_top.sv
module calret_top
  import calret_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int DW    = 28,
  parameter int DEPTH = 6,
  parameter int AW    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCH-1:0]    chainEn,
  input  logic              regWe,
  input  logic [AW-1:0]     regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic [NCH-1:0]    rstValid,
  output logic [2:0]        rstIdx,
  output logic [NCH*DW-1:0] rstData
);
  chainStrobe_t           strobes [NCH];
  logic [NCH-1:0][DW-1:0] dataRegs;

  calret_ctrl #(.NCH(NCH), .DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .chainEn(chainEn), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .dataRegs(dataRegs),
    .regRdata(regRdata), .strobes(strobes), .rstValid(rstValid),
    .rstIdx(rstIdx)
  );

  calret_dp #(.NCH(NCH), .DW(DW), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regWdata(regWdata),
    .rstIdx(rstIdx), .dataRegs(dataRegs), .rstData(rstData)
  );
endmodule

// File: tb/tb_calret_top.sv
module tb_calret_top;
  localparam int NCH = 3;
  localparam int DW  = 28;
  localparam int AW  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NCH-1:0]    chainEn = '1;
  logic              regWe = 1'b0;
  logic [AW-1:0]     regAddr = '0;
  logic [31:0]       regWdata = '0;
  logic [31:0]       regRdata;
  logic [NCH-1:0]    rstValid;
  logic [2:0]        rstIdx;
  logic [NCH*DW-1:0] rstData;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] mdl [NCH][6];

  always #2.5 clk = ~clk;

  calret_top dut (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] cmdA(int c);  return AW'(1 + 2 * c); endfunction
  function automatic logic [AW-1:0] dataA(int c); return AW'(2 + 2 * c); endfunction
  function automatic logic [31:0] cmdWord(int idx, bit wr);
    return 32'(idx & 7) | (32'(wr) << 3) | (32'd1 << 4);
  endfunction

  task automatic regWrite(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [AW-1:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdata;
  endtask

  // start an access and count the cycles the start bit reads 1
  task automatic access(input int c, input int idx, input bit wr, output int cyc);
    logic [31:0] v;
    regWrite(cmdA(c), cmdWord(idx, wr));
    cyc = 0;
    for (int k = 0; k < 10; k++) begin
      regRead(cmdA(c), v);
      if (!v[4]) break;
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic tblWrite(input int c, input int idx, input logic [DW-1:0] d, input string req);
    int cyc;
    regWrite(dataA(c), 32'(d));
    access(c, idx, 1'b1, cyc);
    check(cyc == 2, req, cyc, 2);
  endtask

  task automatic tblRead(input int c, input int idx, output logic [DW-1:0] d);
    int cyc;
    logic [31:0] v;
    access(c, idx, 1'b0, cyc);
    check(cyc == 2, "R3 read latency", cyc, 2);
    regRead(dataA(c), v);
    d = v[DW-1:0];
  endtask

  task automatic walkCheck(input logic [5:0] mask);
    logic [31:0] v;
    regWrite(AW'(0), 32'h81 | (32'(mask) << 1));
    for (int k = 0; k < 6; k++) begin
      regRead(AW'(0), v);
      check(v[7] == 1'b1, "R7 force bit during walk", v[7], 1);
      check(rstIdx == 3'(k), "R8 restore index", rstIdx, k);
      for (int c = 0; c < NCH; c++) begin
        check(rstValid[c] == (mask[k] && chainEn[c]), "R8 valid strobe",
              rstValid[c], mask[k] && chainEn[c]);
        if (rstValid[c])
          check(rstData[c*DW +: DW] == mdl[c][k], "R8 restore data",
                rstData[c*DW +: DW], mdl[c][k]);
      end
      @(negedge clk);
    end
    regRead(AW'(0), v);
    check(v[7] == 1'b0, "R7 force clears after 6 cycles", v[7], 0);
    check(rstValid == '0, "R8 no strobe after walk", rstValid, 0);
  endtask

  initial begin
    #(5 * 20000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [DW-1:0] d;
    int cyc;
    void'($urandom(32'd20240611));
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < 6; i++) mdl[c][i] = '0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 2 * NCH + 1; a++) begin
      regRead(AW'(a), v);
      check(v == 0, "R1 register reset", v, 0);
    end
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < 6; i++) begin
        tblRead(c, i, d);
        check(d == 0, "R1 table reset", d, 0);
      end

    // R2 random traffic against the scoreboard
    for (int n = 0; n < 60; n++) begin
      int c = int'($urandom_range(NCH - 1));
      int i = int'($urandom_range(5));
      if ($urandom_range(1) == 1) begin
        d = DW'($urandom);
        tblWrite(c, i, d, "R3 write latency");
        mdl[c][i] = d;
      end else begin
        tblRead(c, i, d);
        check(d == mdl[c][i], "R2 read back", d, mdl[c][i]);
      end
    end

    // R4 writes during a busy access are ignored
    regWrite(dataA(0), 32'h0AAA_5555);
    regWrite(cmdA(0), cmdWord(1, 1'b1));
    regWe = 1'b1; regAddr = cmdA(0); regWdata = cmdWord(2, 1'b1);
    @(negedge clk);
    regAddr = dataA(0); regWdata = 32'h0123_4567;
    @(negedge clk);
    regWe = 1'b0;
    mdl[0][1] = 28'hAAA_5555;
    regRead(cmdA(0), v);
    check(v[4:0] == 5'h09, "R4 command kept", v[4:0], 5'h09);
    regRead(dataA(0), v);
    check(v[DW-1:0] == 28'hAAA_5555, "R4 data kept", v[DW-1:0], 28'hAAA_5555);
    tblRead(0, 1, d);
    check(d == mdl[0][1], "R4 entry 1 written", d, mdl[0][1]);
    tblRead(0, 2, d);
    check(d == mdl[0][2], "R4 entry 2 untouched", d, mdl[0][2]);

    // R5 masked-off chain
    chainEn = 3'b101;
    regWrite(dataA(1), 32'h0FED_CBA9);
    access(1, 0, 1'b1, cyc);
    check(cyc == 1, "R5 masked chain latency", cyc, 1);
    chainEn = 3'b111;
    tblRead(1, 0, d);
    check(d == mdl[1][0], "R5 table unchanged", d, mdl[1][0]);

    // R6 out-of-range indices
    for (int i = 6; i < 8; i++) begin
      tblWrite(2, i, 28'h1234567, "R6 oob write latency");
      tblRead(2, i, d);
      check(d == 0, "R6 oob read", d, 0);
    end
    for (int i = 0; i < 6; i++) begin
      tblRead(2, i, d);
      check(d == mdl[2][i], "R6 entries untouched", d, mdl[2][i]);
    end

    // R7 R8 restore walks
    walkCheck(6'h10);
    chainEn = 3'b011;
    for (int n = 0; n < 4; n++) walkCheck(6'($urandom));
    chainEn = 3'b111;
    walkCheck(6'h3F);

    // R10 control writes ignored during a walk
    regWrite(AW'(0), 32'h81 | (32'h05 << 1));
    regWrite(AW'(0), 32'h0);
    regRead(AW'(0), v);
    check(v[7:0] == 8'h8B, "R10 control frozen", v[7:0], 8'h8B);
    repeat (6) @(negedge clk);
    regRead(AW'(0), v);
    check(v[7:0] == 8'h0B, "R10 fields kept after walk", v[7:0], 8'h0B);

    // R9 force without enable, and clearing the control register
    regWrite(AW'(0), 32'h80 | (32'h3F << 1));
    for (int k = 0; k < 4; k++) begin
      regRead(AW'(0), v);
      check(v[7] == 1'b0, "R9 no walk without enable", v[7], 0);
      check(rstValid == '0, "R9 no strobe without enable", rstValid, 0);
      @(negedge clk);
    end
    regWrite(AW'(0), 32'h0);
    regRead(AW'(0), v);
    check(v == 0, "R9 control cleared", v, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule